// File: doc/BRIEF.md
# Modified Miller Frame Receiver

This block turns the demodulated reader-to-card envelope of a 106 kbps contactless link into a stream of bytes. The envelope arrives on an asynchronous line that idles high and drops low for each pause. A clock enable that pulses once per carrier cycle paces the timing. The line is synchronised, and its rising edges are located inside each bit period of `ETU_TICKS` carrier ticks. Each period is then classified by the half in which an edge appeared: an early edge, a late edge, no edge, or edges in both halves.

The first late edge starts a frame and fixes the bit-period grid. Decoded bits are gathered least significant first. After every eight data bits, the ninth bit is checked as odd parity and the byte is strobed out. A quiet period that follows a logic 0 ends the frame. The logic 0 that belongs to that end marker is dropped, and any leftover bits of a short frame are strobed right-aligned, together with their count. While the card is transmitting, a blanking input holds the receiver idle.

Top module: `mm_frame_rx`

## Requirements
- R1: After reset, `byte_valid` and `frame_done` are low, and `byte_data`, `bit_count`, `parity_err` and `code_err` are zero.
- R2: A period with a rising edge only in its first half decodes as 1. A period with an edge only in its second half decodes as 0. Data bits fill each byte from bit 0 upward.
- R3: After each group of eight data bits, the next bit is an odd-parity bit. A `byte_valid` pulse then presents the eight bits on `byte_data`. If the eight bits and the parity bit together hold an even number of ones, `parity_err` rises and stays high for the rest of the frame.
- R4: A period with no edge that follows a decoded 0 (or follows the start marker) ends the frame. That 0 is not delivered as data, and `frame_done` pulses once.
- R5: A period with no edge that follows a decoded 1 is a data 0, and the frame continues.
- R6: If the frame ends with k (1..8) bits after the last complete byte-plus-parity group, a `byte_valid` pulse delivers those bits right-aligned (first bit at bit 0). `bit_count` equals k when `frame_done` pulses. `bit_count` is 0 when no bits are left over.
- R7: A period with rising edges in both halves ends the frame at once. It sets `code_err`, pulses `frame_done` with `bit_count` 0, and delivers no partial byte. The bit still waiting for confirmation is dropped.
- R8: While `rx_blank` is high, edges on `rx_in` have no effect and a frame in progress is abandoned without any `byte_valid` or `frame_done` pulse.
- R9: The start edge aligns the bit grid so that it lies in the middle of the second half of the first period. Later edges decode correctly when they are displaced by up to ETU_TICKS/8 ticks from their nominal positions.
- R10: `parity_err` and `code_err` are cleared when the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_tick | input | 1 | One-cycle enable per carrier period |
| rx_in | input | 1 | Asynchronous envelope, low during a pause |
| rx_blank | input | 1 | Holds reception idle while transmitting |
| byte_data | output | 8 | Received byte or right-aligned partial byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| bit_count | output | 4 | Leftover bit count of the frame just ended |
| frame_done | output | 1 | One-cycle pulse at end of frame |
| parity_err | output | 1 | Sticky parity mismatch for the current frame |
| code_err | output | 1 | Sticky coding violation for the current frame |

## Verification
The bench builds the receiver with `ETU_TICKS` = 16 and a three-stage synchroniser. It drives `carrier_tick` on every other clock, so each bit period is 32 clocks long and the tick enable is genuinely gated. The short period lets many whole frames fit in a short run: short 4- and 7-bit frames, multi-byte frames that end on a 0 and on a 1, frames with a corrupted parity bit and with an illegal double-edge period, and a frame with edges jittered by up to three clocks. All of these sit well inside the tolerance window. With blanking raised part-way through a frame, the abandon path is exercised as well.

// File: rtl/mm_rx_pkg.sv
package mm_rx_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  typedef enum logic [1:0] {
    PAT_Y   = 2'd0,
    PAT_X   = 2'd1,
    PAT_Z   = 2'd2,
    PAT_BAD = 2'd3
  } pat_t;

  // Pattern from the edge flags of the two half periods
  function automatic pat_t classify(input logic early, input logic late);
    case ({early, late})
      2'b10:   return PAT_X;
      2'b01:   return PAT_Z;
      2'b00:   return PAT_Y;
      default: return PAT_BAD;
    endcase
  endfunction

  // High when data plus parity bit hold an odd number of ones
  function automatic logic odd_ok(input logic [BYTE_BITS-1:0] d, input logic p);
    return (^d) ^ p;
  endfunction

  // Bits shift in from the top; bring n received bits down to bit 0
  function automatic logic [BYTE_BITS-1:0] right_align(input logic [BYTE_BITS-1:0] sr,
                                                       input logic [CNT_W-1:0] n);
    if (n == '0) return '0;
    return sr >> (BYTE_BITS - int'(n));
  endfunction
endpackage

// File: rtl/mm_rx_sync.sv
module mm_rx_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic blank,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      last_q <= 1'b1;
    end else if (blank) begin
      chain  <= '1;
      last_q <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R8
  blank_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !rise);
endmodule

// File: rtl/mm_etu_timer.sv
module mm_etu_timer
  import mm_rx_pkg::*;
#(
  parameter int ETU_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic start,
  input  logic rise,
  output logic etu_done,
  output pat_t etu_pat
);
  localparam int PH_W = $clog2(ETU_TICKS);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(ETU_TICKS - 1);
  localparam logic [PH_W-1:0] HALF_PH  = PH_W'(ETU_TICKS / 2);
  localparam logic [PH_W-1:0] START_PH = PH_W'((3 * ETU_TICKS) / 4);

  logic [PH_W-1:0] phase;
  logic seen_early, seen_late;
  logic early_n, late_n, in_early, wrap;

  assign in_early = phase < HALF_PH;
  assign early_n  = seen_early | (rise & in_early);
  assign late_n   = seen_late | (rise & ~in_early);
  assign wrap     = tick && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      seen_early <= 1'b0;
      seen_late  <= 1'b0;
      etu_done   <= 1'b0;
      etu_pat    <= PAT_Y;
    end else if (start) begin
      phase      <= START_PH;
      seen_early <= 1'b0;
      seen_late  <= 1'b1;
      etu_done   <= 1'b0;
    end else if (!active) begin
      seen_early <= 1'b0;
      seen_late  <= 1'b0;
      etu_done   <= 1'b0;
    end else if (wrap) begin
      phase      <= '0;
      etu_done   <= 1'b1;
      etu_pat    <= classify(early_n, late_n);
      seen_early <= 1'b0;
      seen_late  <= 1'b0;
    end else begin
      etu_done   <= 1'b0;
      if (tick) phase <= phase + 1'b1;
      seen_early <= early_n;
      seen_late  <= late_n;
    end
  end
endmodule

// File: rtl/mm_frame_ctrl.sv
module mm_frame_ctrl
  import mm_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blank,
  input  logic rise,
  input  logic etu_done,
  input  pat_t etu_pat,
  output logic active,
  output logic start,
  output logic commit,
  output logic commit_bit,
  output logic end_ok,
  output logic end_err
);
  logic sof_etu, pend_v, pend_b;
  logic take, take_bit;

  assign start = ~active & rise & ~blank;

  // A decoded bit is held one period so an end marker can withdraw it
  always_comb begin
    take     = 1'b0;
    take_bit = 1'b0;
    if (etu_pat == PAT_X) begin
      take     = 1'b1;
      take_bit = 1'b1;
    end else if (etu_pat == PAT_Z) begin
      take = 1'b1;
    end else if (etu_pat == PAT_Y && pend_v && pend_b) begin
      take = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sof_etu    <= 1'b0;
      pend_v     <= 1'b0;
      pend_b     <= 1'b0;
      commit     <= 1'b0;
      commit_bit <= 1'b0;
      end_ok     <= 1'b0;
      end_err    <= 1'b0;
    end else begin
      commit  <= 1'b0;
      end_ok  <= 1'b0;
      end_err <= 1'b0;
      if (blank) begin
        active <= 1'b0;
        pend_v <= 1'b0;
      end else if (start) begin
        active  <= 1'b1;
        sof_etu <= 1'b1;
        pend_v  <= 1'b0;
      end else if (active && etu_done) begin
        if (sof_etu) begin
          sof_etu <= 1'b0;
        end else if (etu_pat == PAT_BAD) begin
          end_err <= 1'b1;
          active  <= 1'b0;
          pend_v  <= 1'b0;
        end else if (take) begin
          if (pend_v) begin
            commit     <= 1'b1;
            commit_bit <= pend_b;
          end
          pend_v <= 1'b1;
          pend_b <= take_bit;
        end else begin
          end_ok <= 1'b1;
          active <= 1'b0;
          pend_v <= 1'b0;
        end
      end
    end
  end

  // R4
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_ok |-> !active);
endmodule

// File: rtl/mm_byte_asm.sv
module mm_byte_asm
  import mm_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof,
  input  logic                 commit,
  input  logic                 commit_bit,
  input  logic                 end_ok,
  input  logic                 end_err,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 byte_valid,
  output logic [CNT_W-1:0]     bit_count,
  output logic                 frame_done,
  output logic                 parity_err,
  output logic                 code_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic [BYTE_BITS-1:0] sr;
  logic [CNT_W-1:0]     slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      slot       <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      bit_count  <= '0;
      frame_done <= 1'b0;
      parity_err <= 1'b0;
      code_err   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      if (sof) begin
        sr         <= '0;
        slot       <= '0;
        parity_err <= 1'b0;
        code_err   <= 1'b0;
      end else if (commit) begin
        if (slot == FULL) begin
          byte_data  <= sr;
          byte_valid <= 1'b1;
          slot       <= '0;
          if (!odd_ok(sr, commit_bit)) parity_err <= 1'b1;
        end else begin
          sr   <= {commit_bit, sr[BYTE_BITS-1:1]};
          slot <= slot + 1'b1;
        end
      end else if (end_ok) begin
        frame_done <= 1'b1;
        bit_count  <= slot;
        slot       <= '0;
        if (slot != '0) begin
          byte_valid <= 1'b1;
          byte_data  <= right_align(sr, slot);
        end
      end else if (end_err) begin
        frame_done <= 1'b1;
        bit_count  <= '0;
        code_err   <= 1'b1;
        slot       <= '0;
      end
    end
  end

  // R3
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err && !sof) |=> parity_err);
  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_count <= FULL));
  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err) |-> (frame_done && bit_count == '0));
endmodule

// File: rtl/mm_frame_rx.sv
module mm_frame_rx
  import mm_rx_pkg::*;
#(
  parameter int ETU_TICKS   = 128,
  parameter int SYNC_STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_tick,
  input  logic       rx_in,
  input  logic       rx_blank,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic [3:0] bit_count,
  output logic       frame_done,
  output logic       parity_err,
  output logic       code_err
);
  logic rise, active, start, etu_done;
  logic commit, commit_bit, end_ok, end_err;
  pat_t etu_pat;

  mm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .blank(rx_blank), .rise(rise)
  );

  mm_etu_timer #(.ETU_TICKS(ETU_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(carrier_tick), .active(active),
    .start(start), .rise(rise), .etu_done(etu_done), .etu_pat(etu_pat)
  );

  mm_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .blank(rx_blank), .rise(rise),
    .etu_done(etu_done), .etu_pat(etu_pat), .active(active), .start(start),
    .commit(commit), .commit_bit(commit_bit), .end_ok(end_ok), .end_err(end_err)
  );

  mm_byte_asm u_asm (
    .clk(clk), .rst_n(rst_n), .sof(start), .commit(commit),
    .commit_bit(commit_bit), .end_ok(end_ok), .end_err(end_err),
    .byte_data(byte_data), .byte_valid(byte_valid), .bit_count(bit_count),
    .frame_done(frame_done), .parity_err(parity_err), .code_err(code_err)
  );
endmodule

// File: tb/mm_frame_rx_tb.sv
module mm_frame_rx_tb;
  localparam int ETU   = 16;
  localparam int E     = ETU * 2;
  localparam int PAUSE = 5;

  typedef struct {
    bit         done;
    logic [7:0] data;
    int         cnt;
    bit         perr;
    bit         cerr;
  } ev_t;

  logic clk = 0, rst_n = 0, carrier_tick = 0, rx_in = 1, rx_blank = 0;
  logic [7:0] byte_data;
  logic       byte_valid, frame_done, parity_err, code_err;
  logic [3:0] bit_count;

  ev_t   expq[$];
  bit    fbits[$];
  int    pats[$];   // 0 quiet, 1 early edge, 2 late edge, 3 both halves
  int    checks = 0, errors = 0, ev_seen = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mm_frame_rx #(.ETU_TICKS(ETU), .SYNC_STAGES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .rx_in(rx_in),
    .rx_blank(rx_blank), .byte_data(byte_data), .byte_valid(byte_valid),
    .bit_count(bit_count), .frame_done(frame_done), .parity_err(parity_err),
    .code_err(code_err)
  );

  initial forever begin
    @(negedge clk);
    carrier_tick = ~carrier_tick;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares design strobes against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        ev_seen++;
        if (expq.size() == 0 || expq[0].done) begin
          chk(0, cur_req, "unexpected byte", byte_data, -1);
        end else begin
          ev_t e;
          e = expq.pop_front();
          chk(byte_data == e.data, cur_req, "byte value", byte_data, e.data);
          chk(parity_err == e.perr, cur_req, "parity flag at byte", parity_err, e.perr);
        end
      end
      if (frame_done) begin
        ev_seen++;
        if (expq.size() == 0 || !expq[0].done) begin
          chk(0, cur_req, "unexpected frame end", 1, 0);
        end else begin
          ev_t e;
          e = expq.pop_front();
          chk(bit_count == e.cnt, cur_req, "bit count", bit_count, e.cnt);
          chk(parity_err == e.perr, cur_req, "parity flag at end", parity_err, e.perr);
          chk(code_err == e.cerr, cur_req, "code flag at end", code_err, e.cerr);
        end
      end
    end
  end

  function automatic void add_byte(input logic [7:0] b, input bit bad);
    for (int i = 0; i < 8; i++) fbits.push_back(b[i]);
    fbits.push_back((~^b) ^ bad);
  endfunction

  function automatic void add_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) fbits.push_back(v[i]);
  endfunction

  // Line code: 1 early edge; 0 quiet after 1, late edge otherwise
  function automatic void build_pats(input bit bad_tail);
    bit prev = 0;
    pats.delete();
    pats.push_back(2);
    foreach (fbits[i]) begin
      if (fbits[i]) pats.push_back(1);
      else pats.push_back(prev ? 0 : 2);
      prev = fbits[i];
    end
    if (bad_tail) pats.push_back(3);
    else begin
      pats.push_back(prev ? 0 : 2);
      pats.push_back(0);
    end
  endfunction

  function automatic void expect_frame(input bit bad_tail);
    int n = bad_tail ? fbits.size() - 1 : fbits.size();
    int groups = n / 9;
    int rem = n % 9;
    bit perr = 0;
    ev_t e;
    for (int g = 0; g < groups; g++) begin
      logic [7:0] d = '0;
      for (int i = 0; i < 8; i++) d[i] = fbits[g*9+i];
      if (((^d) ^ fbits[g*9+8]) != 1'b1) perr = 1;
      e = '{done: 0, data: d, cnt: 0, perr: perr, cerr: 0};
      expq.push_back(e);
    end
    if (!bad_tail && rem > 0) begin
      logic [7:0] d = '0;
      for (int i = 0; i < rem; i++) d[i] = fbits[groups*9+i];
      e = '{done: 0, data: d, cnt: 0, perr: perr, cerr: 0};
      expq.push_back(e);
    end
    e = '{done: 1, data: 8'h00, cnt: bad_tail ? 0 : rem, perr: perr, cerr: bad_tail};
    expq.push_back(e);
  endfunction

  task automatic drive_pats(input bit jitter);
    int edges[$];
    int len, base;
    base = PAUSE + 1;
    foreach (pats[k]) begin
      int j = (jitter && k > 0) ? ((k * 5) % 7) - 3 : 0;
      if (pats[k] == 1 || pats[k] == 3) edges.push_back(k*E - E/2 + j);
      if (pats[k] == 2 || pats[k] == 3) edges.push_back(k*E + j);
    end
    len = pats.size() * E + base + 4;
    for (int c = 0; c < len; c++) begin
      logic v = 1'b1;
      foreach (edges[i])
        if (c >= base + edges[i] - PAUSE && c < base + edges[i]) v = 1'b0;
      @(negedge clk);
      rx_in = v;
    end
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic run_frame(input string req, input bit bad_tail, input bit jitter);
    cur_req = req;
    build_pats(bad_tail);
    expect_frame(bad_tail);
    drive_pats(jitter);
    repeat (3 * E) @(negedge clk);
    chk(expq.size() == 0, req, "events still pending", expq.size(), 0);
    expq.delete();
    fbits.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen_before;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(byte_valid == 0, "R1", "byte_valid", byte_valid, 0);
    chk(frame_done == 0, "R1", "frame_done", frame_done, 0);
    chk(byte_data == 0, "R1", "byte_data", byte_data, 0);
    chk(bit_count == 0, "R1", "bit_count", bit_count, 0);
    chk(parity_err == 0 && code_err == 0, "R1", "error flags", {parity_err, code_err}, 0);
    repeat (2 * E) @(negedge clk);

    // R6 / R2: 7-bit short frame
    add_bits(8'h26, 7);
    run_frame("R6", 0, 0);
    // R2 / R3 / R4: two full bytes, last bit a 0
    add_byte(8'h93, 0); add_byte(8'h20, 0);
    run_frame("R4", 0, 0);
    // R5: quiet periods after 1 are data zeros, frame ends after a 1
    add_byte(8'h00, 0); add_byte(8'hFF, 0); add_byte(8'h55, 0);
    run_frame("R5", 0, 0);
    // R3: corrupted parity on the first byte, flag stays high
    add_byte(8'hA5, 1); add_byte(8'h3C, 0);
    run_frame("R3", 0, 0);
    // R10: next frame starts with flags cleared
    add_byte(8'h11, 0);
    run_frame("R10", 0, 0);
    // R7: both-half edges after a byte and two bits
    add_byte(8'h5A, 0); add_bits(8'h03, 2);
    run_frame("R7", 1, 0);
    // R10: code flag cleared by the next start
    add_bits(8'h0B, 4);
    run_frame("R10", 0, 0);
    chk(code_err == 0, "R10", "code_err after clean frame", code_err, 0);
    // R2: frame with 8 data bits and no parity
    add_bits(8'hC9, 8);
    run_frame("R2", 0, 0);

    // R8: frame abandoned by blanking part-way through
    cur_req = "R8";
    seen_before = ev_seen;
    add_byte(8'h6D, 0); add_byte(8'h12, 0);
    build_pats(0);
    fork
      drive_pats(0);
      begin
        repeat (6 * E) @(negedge clk);
        rx_blank = 1'b1;
      end
    join
    repeat (2 * E) @(negedge clk);
    rx_blank = 1'b0;
    repeat (2 * E) @(negedge clk);
    chk(ev_seen == seen_before, "R8", "strobes during blank", ev_seen - seen_before, 0);
    fbits.delete();
    // R8: a whole frame while blanked
    rx_blank = 1'b1;
    add_byte(8'h42, 0);
    build_pats(0);
    drive_pats(0);
    repeat (2 * E) @(negedge clk);
    rx_blank = 1'b0;
    repeat (2 * E) @(negedge clk);
    chk(ev_seen == seen_before, "R8", "strobes from blanked frame", ev_seen - seen_before, 0);
    fbits.delete();
    // R8: receiver still works after blanking
    add_byte(8'hE7, 0);
    run_frame("R8", 0, 0);

    // R9: edges displaced by up to three clocks
    add_byte(8'hC3, 0); add_byte(8'h7E, 0); add_bits(8'h05, 3);
    run_frame("R9", 0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule